// File: doc/BRIEF.md
# Synchronous Burst SRAM with Dual Address Strobes

This block is a synthesizable synchronous static RAM with a 64-bit word, a parameterized number of words and eight byte lanes. Every access is set up on a clock edge. A processor-side or a controller-side address strobe loads a start address into a registered front end. From then on, an advance strobe steps a two-bit burst counter through the four-word block that holds the start address. The low two address bits follow either an interleaved (XOR) order or a linear (modulo-4) order.

A burst either reads the word at its current address or writes it through byte-lane enables. The read data path is either registered, which adds one cycle, or flow-through. A static configuration input picks the path. A sleep input holds the block in a low-power state and keeps the stored contents. After sleep is released, new strobes stay blocked for a parameterized number of edges. The output enable gates the data and the valid flag combinationally.

Top module: `burst_sram`

## Requirements
- R1: An accepted strobe loads `addr` at that edge, and the first transfer of the burst is the word at `addr`.
- R2: With `order_lin`=0, transfer j of a burst uses low address bits `addr[1:0] XOR j[1:0]`. The upper bits stay fixed.
- R3: With `order_lin`=1, transfer j uses low bits `(addr[1:0]+j) mod 4`. After four advances the sequence repeats within the same four-word block.
- R4: The burst address moves one step only on an edge where `step_n` is 0. When `step_n` is 1 it is held.
- R5: `strb_cpu_n` is ignored while `sel_n` is 1. `strb_ctl_n` is acted on whatever the value of `sel_n`. A controller strobe taken while any enable is inactive ends the burst. When both strobes are accepted, the processor strobe wins.
- R6: `sel_hi` (active 1) and `sel_lo_n` (active 0) are sampled only on an edge that accepts a strobe. On any other edge they have no effect.
- R7: With `flow_thru`=1, read data is valid after the edge that sets the burst address. With `flow_thru`=0, it is valid one edge later.
- R8: Byte lane i (`din[8i+7:8i]`) is written when `wr_all_n`=0, or when `lane_wr_n`=0 and `lane_sel_n[i]`=0. Otherwise the lane is left unchanged.
- R9: An edge that accepts the processor strobe never writes. It is a read setup. An edge that accepts the controller strobe writes at `addr`. An edge without a strobe writes at the current burst address. Nothing is written while the block is deselected.
- R10: After an edge that deselects the block, `dout_vld` is 0 no later than after the following edge.
- R11: While `sleep`=1 no write occurs, no burst starts and any burst ends. The first WAKE_CYC edges after release ignore strobes. Stored words are kept.
- R12: `dout_vld` is 1 only after a read edge (selected, no write) with `oe_n`=0. Whenever `dout_vld` is 0, `dout` is all zeros.
- R13: After reset no burst is active and `dout`/`dout_vld` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address sampled with a strobe |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Primary enable, active low |
| sel_hi | input | 1 | Secondary enable, active high |
| sel_lo_n | input | 1 | Secondary enable, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Byte-lane write qualifier, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Low-power hold request |
| order_lin | input | 1 | 1 linear, 0 interleaved burst order |
| flow_thru | input | 1 | 1 flow-through, 0 registered read path |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, zero when not valid |
| dout_vld | output | 1 | Read data valid |

## Verification
The assertions take `order_lin` and `flow_thru` to be static outside reset, and they take the enables to behave as ordinary levels sampled at the clock. The latency and stepping properties depend on that. The bench changes the two configuration inputs only while reset is held. It drives every other input half a cycle away from the sampling edge. It checks each burst sweep with its own address and memory model. Every start address is swept in all four configurations, and all 256 byte-lane masks are applied.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

   // Low address bits of a burst step for either order
   function automatic logic [1:0] burst_low(input logic [1:0] base,
                                            input logic [1:0] cnt,
                                            input logic       lin);
      return lin ? (base + cnt) : (base ^ cnt);
   endfunction

endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int LANES    = 8,
   parameter int WAKE_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              strb_cpu_n,
   input  logic              strb_ctl_n,
   input  logic              step_n,
   input  logic              sel_n,
   input  logic              sel_hi,
   input  logic              sel_lo_n,
   input  logic              wr_all_n,
   input  logic              lane_wr_n,
   input  logic [LANES-1:0]  lane_sel_n,
   input  logic              sleep,
   input  logic              order_lin,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [LANES-1:0]  wr_lanes,
   output logic              acc_rd,
   output logic              active,
   output logic              rec_busy
);
   localparam int REC_W = $clog2(WAKE_CYC + 1);
   localparam logic [REC_W-1:0] REC_LOAD = REC_W'(WAKE_CYC);

   logic [ADDR_W-1:0] base_q, base_d;
   logic [1:0]        cnt_q, cnt_d;
   logic              act_d;
   logic [REC_W-1:0]  rec_q;
   logic              open_ok, take_cpu, take_ctl, start, sel_ok;
   logic [LANES-1:0]  req_lanes;

   assign rec_busy = (rec_q != '0);
   assign open_ok  = !sleep && !rec_busy;
   assign take_cpu = open_ok && !strb_cpu_n && !sel_n;
   assign take_ctl = open_ok && !strb_ctl_n && !take_cpu;
   assign start    = take_cpu || take_ctl;
   assign sel_ok   = sel_hi && !sel_lo_n && !sel_n;

   assign req_lanes = !wr_all_n ? '1 : (!lane_wr_n ? ~lane_sel_n : '0);

   always_comb begin
      act_d  = active;
      base_d = base_q;
      cnt_d  = cnt_q;
      if (sleep) begin
         act_d = 1'b0;
      end else if (start) begin
         act_d  = sel_ok;
         base_d = addr;
         cnt_d  = 2'd0;
      end else if (active && !step_n) begin
         cnt_d = cnt_q + 2'd1;
      end
   end

   assign wr_addr  = {base_d[ADDR_W-1:2], burst_low(base_d[1:0], cnt_d, order_lin)};
   assign cur_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, order_lin)};
   assign wr_lanes = (act_d && !take_cpu) ? req_lanes : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         base_q <= '0;
         cnt_q  <= 2'd0;
         acc_rd <= 1'b0;
      end else begin
         active <= act_d;
         base_q <= base_d;
         cnt_q  <= cnt_d;
         acc_rd <= act_d && (wr_lanes == '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rec_q <= '0;
      else if (sleep)     rec_q <= REC_LOAD;
      else if (rec_busy)  rec_q <= rec_q - REC_W'(1);
   end

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 8
) (
   input  logic               clk,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [LANES-1:0]   wr_lanes,
   input  logic [LANES*8-1:0] din,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [LANES*8-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] cells [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_lanes[g]) cells[wr_addr] <= din[8*g +: 8];
      end
      assign rdata[8*g +: 8] = cells[rd_addr];
   end

endmodule

// File: rtl/burst_sram_rdpath.sv
module burst_sram_rdpath #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flow_thru,
   input  logic [DATA_W-1:0] rdata,
   input  logic              acc_rd,
   output logic [DATA_W-1:0] data_o,
   output logic              vld_o
);
   logic [DATA_W-1:0] pipe_data;
   logic              pipe_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_data <= '0;
         pipe_vld  <= 1'b0;
      end else begin
         pipe_data <= rdata;
         pipe_vld  <= acc_rd;
      end
   end

   assign data_o = flow_thru ? rdata  : pipe_data;
   assign vld_o  = flow_thru ? acc_rd : pipe_vld;

endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int DATA_W   = 64,
   parameter int WAKE_CYC = 4,
   localparam int LANES   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              strb_cpu_n,
   input  logic              strb_ctl_n,
   input  logic              step_n,
   input  logic              sel_n,
   input  logic              sel_hi,
   input  logic              sel_lo_n,
   input  logic              wr_all_n,
   input  logic              lane_wr_n,
   input  logic [LANES-1:0]  lane_sel_n,
   input  logic              oe_n,
   input  logic              sleep,
   input  logic              order_lin,
   input  logic              flow_thru,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_vld
);
   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("DATA_W must be a multiple of 8");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must cover a four-word burst block");
   end
   if (WAKE_CYC < 1) begin : g_bad_wake
      $error("WAKE_CYC must be at least 1");
   end

   logic [ADDR_W-1:0] cur_addr, wr_addr;
   logic [LANES-1:0]  wr_lanes;
   logic              acc_rd, active, rec_busy, vld_int;
   logic [DATA_W-1:0] rdata, data_int;

   burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .WAKE_CYC(WAKE_CYC)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
      .sel_n(sel_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
      .wr_all_n(wr_all_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
      .sleep(sleep), .order_lin(order_lin),
      .cur_addr(cur_addr), .wr_addr(wr_addr), .wr_lanes(wr_lanes),
      .acc_rd(acc_rd), .active(active), .rec_busy(rec_busy)
   );

   burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
      .clk(clk), .wr_addr(wr_addr), .wr_lanes(wr_lanes), .din(din),
      .rd_addr(cur_addr), .rdata(rdata)
   );

   burst_sram_rdpath #(.DATA_W(DATA_W)) u_rdpath (
      .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .rdata(rdata),
      .acc_rd(acc_rd), .data_o(data_int), .vld_o(vld_int)
   );

   assign dout_vld = vld_int && !oe_n;
   assign dout     = dout_vld ? data_int : '0;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 8,
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strb_cpu_n,
   input logic              strb_ctl_n,
   input logic              step_n,
   input logic              sel_n,
   input logic              sel_hi,
   input logic              sleep,
   input logic              order_lin,
   input logic              flow_thru,
   input logic [DATA_W-1:0] dout,
   input logic              dout_vld,
   input logic [ADDR_W-1:0] cur_addr,
   input logic [LANES-1:0]  wr_lanes,
   input logic              acc_rd,
   input logic              vld_int,
   input logic              active,
   input logic              rec_busy
);
   assert_pipe_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !flow_thru |=> (vld_int == $past(acc_rd)));

   assert_zero_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_vld |-> (dout == '0));

   assert_sleep_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (wr_lanes == '0));

   assert_cpu_setup_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_cpu_n && !sel_n) |-> (wr_lanes == '0));

   assert_hold_on_suspend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_cpu_n && strb_ctl_n && step_n && !sleep) |=> $stable(cur_addr));

   assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (strb_cpu_n && strb_ctl_n && !step_n && !sleep && active && order_lin)
      |=> ((cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1)
           && (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]))));

   assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_ctl_n && !sel_hi && !sleep && !rec_busy) |=> !acc_rd);

endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
   .step_n(step_n), .sel_n(sel_n), .sel_hi(sel_hi), .sleep(sleep),
   .order_lin(order_lin), .flow_thru(flow_thru), .dout(dout), .dout_vld(dout_vld),
   .cur_addr(cur_addr), .wr_lanes(wr_lanes), .acc_rd(acc_rd), .vld_int(vld_int),
   .active(active), .rec_busy(rec_busy)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
   localparam int AW = 6;
   localparam int DW = 64;
   localparam int NL = 8;
   localparam int WAKE = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic          strb_cpu_n, strb_ctl_n, step_n, sel_n, sel_hi, sel_lo_n;
   logic          wr_all_n, lane_wr_n, oe_n, sleep, order_lin, flow_thru;
   logic [NL-1:0] lane_sel_n;
   logic [DW-1:0] din, dout;
   logic          dout_vld;

   int total = 0;
   int bad   = 0;
   logic [DW-1:0] model [64];

   always #2.5 clk = ~clk;

   burst_sram #(.ADDR_W(AW), .DATA_W(DW), .WAKE_CYC(WAKE)) u_burst_sram (
      .clk(clk), .rst_n(rst_n), .addr(addr), .strb_cpu_n(strb_cpu_n),
      .strb_ctl_n(strb_ctl_n), .step_n(step_n), .sel_n(sel_n), .sel_hi(sel_hi),
      .sel_lo_n(sel_lo_n), .wr_all_n(wr_all_n), .lane_wr_n(lane_wr_n),
      .lane_sel_n(lane_sel_n), .oe_n(oe_n), .sleep(sleep), .order_lin(order_lin),
      .flow_thru(flow_thru), .din(din), .dout(dout), .dout_vld(dout_vld)
   );

   function automatic logic [DW-1:0] pat(input int a);
      return 64'hC3A5_0F1E_7B2D_9604 ^ (64'(a + 1) * 64'h0102_0408_1020_4081);
   endfunction

   function automatic logic [AW-1:0] baddr(input logic [AW-1:0] a, input int j, input logic lin);
      logic [1:0] jj;
      jj = j[1:0];
      return {a[AW-1:2], lin ? (a[1:0] + jj) : (a[1:0] ^ jj)};
   endfunction

   function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                           input logic [NL-1:0] m);
      logic [DW-1:0] r;
      r = old;
      for (int i = 0; i < NL; i++) if (m[i]) r[8*i +: 8] = nw[8*i +: 8];
      return r;
   endfunction

   task automatic idle();
      strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; step_n = 1'b1;
      sel_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
      wr_all_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = '1;
      oe_n = 1'b0; sleep = 1'b0; addr = '0; din = '0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string rq, input logic ev, input logic [DW-1:0] ed);
      total++;
      if (dout_vld !== ev || dout !== ed) begin
         bad++;
         $display("FAIL %s: got vld=%0b data=%h, expected vld=%0b data=%h",
                  rq, dout_vld, dout, ev, ed);
      end
   endtask

   task automatic do_reset(input logic lin, input logic ft);
      rst_n = 1'b0;
      idle();
      order_lin = lin;
      flow_thru = ft;
      repeat (3) tick();
      chk("R13 reset outputs", 1'b0, '0);
      rst_n = 1'b1;
      tick();
      chk("R13 idle after reset", 1'b0, '0);
   endtask

   task automatic fill();
      for (int a = 0; a < 64; a++) begin
         idle(); strb_ctl_n = 1'b0; addr = AW'(a); wr_all_n = 1'b0; din = pat(a);
         tick();
         model[a] = pat(a);
      end
      idle();
   endtask

   task automatic deselect();
      idle(); strb_ctl_n = 1'b0; sel_hi = 1'b0;
      tick();
      idle();
      tick();
      chk("R10 deselected output off", 1'b0, '0);
   endtask

   task automatic rd_one(input string rq, input int a);
      idle(); strb_ctl_n = 1'b0; addr = AW'(a);
      tick();
      if (!flow_thru) begin idle(); tick(); end
      chk(rq, 1'b1, model[a]);
      deselect();
   endtask

   task automatic rd_burst(input int a, input logic use_ctl);
      logic [AW-1:0] ea;
      string rq;
      rq = order_lin ? "R3 linear burst" : "R2 interleaved burst";
      for (int j = 0; j <= 8; j++) begin
         idle();
         if (j == 0) begin
            addr = AW'(a);
            if (use_ctl) strb_ctl_n = 1'b0; else strb_cpu_n = 1'b0;
         end else begin
            step_n = (j < 8) ? 1'b0 : 1'b1;
         end
         tick();
         if (flow_thru) begin
            ea = baddr(AW'(a), (j < 8) ? j : 7, order_lin);
            chk(j == 0 ? "R1 R7 first word flow" : rq, 1'b1, model[ea]);
         end else if (j == 0) begin
            chk("R7 pipelined not yet valid", 1'b0, '0);
         end else begin
            ea = baddr(AW'(a), j - 1, order_lin);
            chk(j == 1 ? "R1 R7 first word pipelined" : rq, 1'b1, model[ea]);
         end
      end
      deselect();
   endtask

   logic done = 1'b0;

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] x;
      logic [NL-1:0] m;
      rst_n = 1'b0;
      idle();
      order_lin = 1'b0;
      flow_thru = 1'b1;
      @(negedge clk);

      // Sweep: every start address, both orders, both read paths, both strobes
      for (int cfg = 0; cfg < 4; cfg++) begin
         do_reset(cfg[0], cfg[1]);
         fill();
         for (int a = 0; a < 64; a++) rd_burst(a, a[0]);
      end

      // Directed cases, flow-through, linear order
      do_reset(1'b1, 1'b1);
      fill();

      // R4 suspend then advance
      idle(); strb_cpu_n = 1'b0; addr = 6'd9; tick();
      chk("R4 start", 1'b1, model[9]);
      idle(); tick(); chk("R4 held 1", 1'b1, model[9]);
      idle(); tick(); chk("R4 held 2", 1'b1, model[9]);
      idle(); step_n = 1'b0; tick(); chk("R4 advanced", 1'b1, model[10]);

      // R5 processor strobe masked by primary enable, controller strobe not
      idle(); strb_cpu_n = 1'b0; sel_n = 1'b1; addr = 6'd40; tick();
      chk("R5 masked processor strobe", 1'b1, model[10]);
      idle(); strb_ctl_n = 1'b0; sel_n = 1'b1; addr = 6'd40; tick();
      chk("R5 controller strobe acts with sel_n high", 1'b0, '0);
      idle(); strb_ctl_n = 1'b0; addr = 6'd40; tick();
      chk("R5 controller strobe read", 1'b1, model[40]);

      // R6 secondary enables ignored without a strobe
      idle(); step_n = 1'b0; sel_hi = 1'b0; sel_lo_n = 1'b1; tick();
      chk("R6 secondary enables ignored", 1'b1, model[41]);
      idle(); strb_cpu_n = 1'b0; sel_lo_n = 1'b1; addr = 6'd44; tick();
      chk("R6 R10 strobe samples secondary enable", 1'b0, '0);

      // R9 processor-strobe write burst with R8 lane masks
      idle(); strb_cpu_n = 1'b0; addr = 6'd20; wr_all_n = 1'b0; din = ~pat(99); tick();
      chk("R9 processor strobe edge is read setup", 1'b1, model[20]);
      x = 64'h1111_2222_3333_4444;
      idle(); lane_wr_n = 1'b0; lane_sel_n = 8'b1010_0101; din = x; tick();
      model[20] = merge(model[20], x, 8'b0101_1010);
      chk("R12 write cycle not valid", 1'b0, '0);
      x = 64'hDEAD_BEEF_0BAD_F00D;
      idle(); step_n = 1'b0; wr_all_n = 1'b0; din = x; tick();
      model[21] = x;
      idle(); step_n = 1'b0; lane_sel_n = '0; din = ~x; tick();
      chk("R8 lane selects need lane_wr_n", 1'b1, model[22]);
      deselect();
      rd_one("R8 R9 masked burst write", 20);
      rd_one("R9 continuation write", 21);

      // R8 all 256 lane masks via controller strobe writes
      for (int k = 0; k < 256; k++) begin
         m = 8'(k);
         x = pat(k + 300);
         idle(); strb_ctl_n = 1'b0; addr = AW'(k % 64); lane_wr_n = 1'b0;
         lane_sel_n = ~m; din = x; tick();
         model[k % 64] = merge(model[k % 64], x, m);
         idle(); strb_ctl_n = 1'b0; addr = AW'(k % 64); tick();
         chk("R8 lane mask sweep", 1'b1, model[k % 64]);
      end
      // R8 global write overrides lane controls
      idle(); strb_ctl_n = 1'b0; addr = 6'd3; wr_all_n = 1'b0; lane_wr_n = 1'b1; din = pat(777); tick();
      model[3] = pat(777);
      deselect();
      rd_one("R8 global write", 3);

      // R9 no write while deselected
      idle(); strb_ctl_n = 1'b0; sel_hi = 1'b0; addr = 6'd5; wr_all_n = 1'b0; din = ~pat(5); tick();
      idle(); step_n = 1'b0; wr_all_n = 1'b0; din = ~pat(6); tick();
      rd_one("R9 deselected write ignored", 5);

      // R12 output enable gating
      idle(); strb_ctl_n = 1'b0; addr = 6'd7; oe_n = 1'b1; tick();
      chk("R12 oe_n high blanks output", 1'b0, '0);
      oe_n = 1'b0; #1;
      chk("R12 oe_n low shows data", 1'b1, model[7]);
      deselect();

      // R11 sleep and wake-up blocking
      idle(); strb_ctl_n = 1'b0; addr = 6'd30; tick();
      chk("R11 before sleep", 1'b1, model[30]);
      idle(); sleep = 1'b1; strb_ctl_n = 1'b0; addr = 6'd30; wr_all_n = 1'b0; din = ~pat(30); tick();
      chk("R11 sleeping", 1'b0, '0);
      idle(); sleep = 1'b1; tick();
      chk("R11 sleeping 2", 1'b0, '0);
      for (int k = 0; k < WAKE; k++) begin
         idle(); strb_ctl_n = 1'b0; addr = 6'd30;
         if (k[0] == 1'b0) begin wr_all_n = 1'b0; din = ~pat(31); end
         tick();
         chk("R11 strobe blocked after wake", 1'b0, '0);
      end
      idle(); strb_ctl_n = 1'b0; addr = 6'd30; tick();
      chk("R11 strobe accepted, contents kept", 1'b1, model[30]);
      deselect();

      // R10 pipelined deselect timing, interleaved order
      do_reset(1'b0, 1'b0);
      fill();
      idle(); strb_cpu_n = 1'b0; addr = 6'd12; tick();
      chk("R7 pipelined setup", 1'b0, '0);
      idle(); step_n = 1'b0; tick();
      chk("R7 pipelined first", 1'b1, model[12]);
      idle(); strb_cpu_n = 1'b0; sel_hi = 1'b0; addr = 6'd50; tick();
      chk("R10 last read still in pipe", 1'b1, model[13]);
      idle(); tick();
      chk("R10 off one edge later", 1'b0, '0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule